// File: doc/BRIEF.md
# Immediate-Masked Packed Word Blend Unit

This block is one stage of a SIMD datapath. From two source vectors it builds a 256-bit result. Each 16-bit word of the result is taken from one source or the other, as an 8-bit immediate mask directs. Mask bit i governs word i of a 128-bit lane. In the full-width mode the same bit also governs the matching word of the upper lane.

A two-bit mode input sets how the upper 128 bits are treated:
- The destructive mode keeps them from the old destination value. In this mode that old value is also presented as the first source.
- The narrow non-destructive mode clears them.
- The wide mode blends them with the same eight mask bits.

The result is registered and appears with a valid flag one clock after the input strobe. The operation produces no status flags. It only reports an error when the mode code is the reserved one.

Top module: `word_blend_unit`

## Requirements
- R1: A synchronous active-high reset clears the result to zero and deasserts out_valid and out_err.
- R2: When in_valid is high, the result, out_valid and out_err are updated at the next rising clock edge. When in_valid is low, out_valid falls at the next edge and the result and out_err hold their values.
- R3: For word i (i = 0 to 7, bits 16*i+15 down to 16*i) of the lower lane, result word i equals src_b word i when mask bit i is 1, and src_a word i when mask bit i is 0. This applies in every mode except the reserved one.
- R4: In mode 2'b00 (destructive), result bits 255:128 equal old_dst bits 255:128.
- R5: In mode 2'b01 (narrow non-destructive), result bits 255:128 are zero.
- R6: In mode 2'b10 (wide), result word i+8 is taken from src_b word i+8 when mask bit i is 1, and from src_a word i+8 otherwise. The mask is not widened.
- R7: In mode 2'b11 (reserved), the result is all zero and out_err is 1. In all other modes out_err is 0.
- R8: No word moves position. Every result word equals the word in the same position of src_a, src_b or old_dst, or is zero. No word crosses the 128-bit lane boundary.
- R9: In the wide mode, each 16-bit word of the upper lane comes from src_a or src_b only, never from old_dst. This is checked with old_dst held at a pattern different from both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe |
| mode | input | 2 | 00 destructive, 01 narrow, 10 wide, 11 reserved |
| mask | input | 8 | Per-word select, 1 picks src_b |
| src_a | input | 256 | First source |
| src_b | input | 256 | Second source |
| old_dst | input | 256 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Reserved mode was used |
| result | output | 256 | Blended result |

## Verification
The hard case is a mode change at the upper lane, because all three treatments look alike unless the bench uses distinct data:
- old_dst must differ from both sources, so that keeping the old value is visible.
- The mask must have mixed bits, so that the reuse of the mask in the upper lane shows.
- The sources must be nonzero, so that clearing shows.

The bench drives random data from a fixed seed with every mode. It adds directed masks of all ones, all zeros, and alternating bits. It also runs idle cycles to check that the result holds.

// File: rtl/word_blend_unit.sv
module word_blend_unit #(
  parameter int WORD_W = 16,
  parameter int LANE_WORDS = 8,
  parameter int LANES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic [1:0] mode,
  input  logic [LANE_WORDS-1:0] mask,
  input  logic [WORD_W*LANE_WORDS*LANES-1:0] src_a,
  input  logic [WORD_W*LANE_WORDS*LANES-1:0] src_b,
  input  logic [WORD_W*LANE_WORDS*LANES-1:0] old_dst,
  output logic out_valid,
  output logic out_err,
  output logic [WORD_W*LANE_WORDS*LANES-1:0] result
);
  localparam int LANE_W = WORD_W * LANE_WORDS;
  localparam int TOTAL_W = LANE_W * LANES;
  localparam logic [1:0] M_DESTR = 2'b00;
  localparam logic [1:0] M_NARROW = 2'b01;
  localparam logic [1:0] M_WIDE = 2'b10;

  logic [TOTAL_W-1:0] blended;
  logic [TOTAL_W-1:0] next_res;
  logic rsv;

  assign rsv = (mode == 2'b11);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar w = 0; w < LANE_WORDS; w++) begin : g_word
      localparam int LO = l*LANE_W + w*WORD_W;
      assign blended[LO +: WORD_W] = mask[w] ? src_b[LO +: WORD_W] : src_a[LO +: WORD_W];
    end
  end

  always_comb begin
    next_res = '0;
    case (mode)
      M_DESTR:  next_res = {old_dst[TOTAL_W-1:LANE_W], blended[LANE_W-1:0]};
      M_NARROW: next_res = {{(TOTAL_W-LANE_W){1'b0}}, blended[LANE_W-1:0]};
      M_WIDE:   next_res = blended;
      default:  next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err <= 1'b0;
      result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        out_err <= rsv;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_err && result == '0));
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid) || $past(rst));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_destr_upper_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == M_DESTR) |=> result[TOTAL_W-1:LANE_W] == $past(old_dst[TOTAL_W-1:LANE_W]));
  assert_narrow_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == M_NARROW) |=> result[TOTAL_W-1:LANE_W] == '0);
  assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b11) |=> (out_err && result == '0));
  assert_no_err_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode != 2'b11) |=> !out_err);
endmodule

// File: tb/tb_word_blend_unit.sv
module tb_word_blend_unit;
  localparam int CLK_P = 10;
  localparam int W = 256;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [1:0] mode = 0;
  logic [7:0] mask = 0;
  logic [W-1:0] src_a = 0, src_b = 0, old_dst = 0;
  logic out_valid, out_err;
  logic [W-1:0] result;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  word_blend_unit dut (.clk, .rst, .in_valid, .mode, .mask, .src_a, .src_b,
    .old_dst, .out_valid, .out_err, .result);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [1:0] m, input logic [7:0] k,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
    logic [W-1:0] r = '0;
    if (m == 2'b11) return '0;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = k[i] ? b[16*i +: 16] : a[16*i +: 16];
    for (int i = 0; i < 8; i++)
      case (m)
        2'b00: r[128+16*i +: 16] = d[128+16*i +: 16];
        2'b10: r[128+16*i +: 16] = k[i] ? b[128+16*i +: 16] : a[128+16*i +: 16];
        default: r[128+16*i +: 16] = '0;
      endcase
    return r;
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [1:0] m, input logic [7:0] k,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
    logic [W-1:0] e;
    @(negedge clk);
    mode = m; mask = k; src_a = a; src_b = b; old_dst = d; in_valid = 1;
    e = model(m, k, a, b, d);
    @(negedge clk);
    in_valid = 0;
    chk({req, " result"}, result, e);
    chk({req, " valid"}, {255'b0, out_valid}, 256'd1);
    chk({req, " err"}, {255'b0, out_err}, {255'b0, m == 2'b11});
  endtask

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk-n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b, d, hold;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk("R1 reset result", result, '0);
    chk("R1 reset valid", {255'b0, out_valid, out_err}, '0);
    rst = 0;
    for (int i = 0; i < 16; i++) begin a[16*i +: 16] = 16'hA000+i; b[16*i +: 16] = 16'hB000+i; d[16*i +: 16] = 16'hD000+i; end
    run("R3 R4 all-zero mask", 2'b00, 8'h00, a, b, d);
    run("R3 R4 all-ones mask", 2'b00, 8'hFF, a, b, d);
    run("R5 narrow alt mask", 2'b01, 8'h55, a, b, d);
    run("R6 R9 wide mask reuse", 2'b10, 8'hA5, a, b, d);
    run("R8 wide ones", 2'b10, 8'hFF, a, b, d);
    run("R7 reserved", 2'b11, 8'h3C, a, b, d);
    run("R7 after reserved", 2'b01, 8'h3C, a, b, d);
    hold = result;
    repeat (3) @(negedge clk);
    chk("R2 hold result", result, hold);
    chk("R2 valid drops", {255'b0, out_valid}, '0);
    for (int t = 0; t < 200; t++) begin
      a = rnd256(); b = rnd256(); d = rnd256();
      run("R3 R8 random", 2'($urandom), 8'($urandom), a, b, d);
    end
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R1 reset again", result, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk-n_fail, n_chk);
    $finish;
  end
endmodule